// File: doc/BRIEF.md
# Multi-Mode Tick Timer

A free-running cycle counter paired with a control word that sets a compare period, one of four run modes, and an interrupt enable with a sticky pending flag. On every clock the low bits of the counter are compared with the period. A hit can reset the counter, halt it, let it run on, or be noticed while the counter stays frozen. The run mode decides which. A hit raises the pending flag only when interrupts are enabled and nothing is already pending.

Software reaches both the counter and the control word through a plain single-cycle register port with a write strobe, a select bit and a combinational read mux. The port has no handshake. Every write is accepted on the edge where the strobe is high, so back-pressure never arises. The interrupt output is a level and stays high until software clears the pending flag.

Top module: `tick_timer`

## Requirements
- R1: After reset the counter, the control word and `irq` are all zero.
- R2: A write with `wr_sel`=1 loads the counter on that edge and replaces that cycle's mode-driven update. A write with `wr_sel`=0 loads the control word. `rd_data` shows the counter when `rd_sel`=1 and the control word when `rd_sel`=0, with no added delay.
- R3: Control word layout: bits [CNT_W-5:0] hold the period, bit CNT_W-4 is pending, bit CNT_W-3 is enable, and bits [CNT_W-1:CNT_W-2] hold the mode (0 frozen, 1 restart, 2 single-run, 3 free-run). The word reads back as written.
- R4: A hit means the low CNT_W-4 counter bits equal the period. Upper counter bits play no part. When the period is below the current low bits, the hit comes only after those bits wrap to zero.
- R5: In mode 0 the counter holds its value, but a hit still counts as a match for the interrupt logic.
- R6: In mode 1 a hit makes the counter 0 on the next edge. Otherwise it counts up by one.
- R7: In mode 2 the counter holds while the hit lasts and counts up otherwise. Rewriting the period lets it resume.
- R8: In mode 3 the counter increments on every edge, including the hit edge.
- R9: On a hit with enable=1 and pending=0, pending becomes 1 on the next edge. With enable=0, pending does not change. Pending stays set until a control-word write clears it.
- R10: `irq` is high exactly when both pending and enable are set. A write that clears pending drops `irq` on the next edge.
- R11: A control-word write takes priority over the hardware setting pending on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 1 counter, 0 control word |
| wr_data | input | CNT_W | Write value |
| rd_sel | input | 1 | Read source: 1 counter, 0 control word |
| rd_data | output | CNT_W | Selected register value |
| irq | output | 1 | Tick interrupt level |

## Verification
A wrong mode decode or a wrong hit comparison shows on `rd_data` as a counter value that departs from the reference model on the very next edge after the hit. That is one cycle, not a whole period later. A pending flag that is set or cleared wrongly shows in the read-back word and on `irq` one edge after the hit or the write. For this reason the bench checks both outputs on every clock, alongside directed checks at the wrap point and at the hold points.

// File: rtl/tick_pkg.sv
package tick_pkg;
  typedef enum logic [1:0] {
    TM_FROZEN  = 2'd0,
    TM_RESTART = 2'd1,
    TM_SINGLE  = 2'd2,
    TM_FREE    = 2'd3
  } tmode_e;
endpackage

// File: rtl/tick_match.sv
module tick_match #(
  parameter int PER_W = 28
) (
  input  logic [PER_W-1:0] cnt_lo,
  input  logic [PER_W-1:0] period,
  output logic             hit
);
  assign hit = (cnt_lo == period);
endmodule

// File: rtl/tick_counter.sv
module tick_counter
  import tick_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  tmode_e           mode,
  input  logic             hit,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt;
    if (load) begin
      cnt_nxt = load_val;
    end else begin
      unique case (mode)
        TM_FROZEN:  cnt_nxt = cnt;
        TM_RESTART: cnt_nxt = hit ? '0 : cnt + 1'b1;
        TM_SINGLE:  cnt_nxt = hit ? cnt : cnt + 1'b1;
        TM_FREE:    cnt_nxt = cnt + 1'b1;
        default:    cnt_nxt = cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end
endmodule

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import tick_pkg::*;
#(
  parameter int CNT_W = 32,
  localparam int PER_W = CNT_W - 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             hit,
  output logic [CNT_W-1:0] word,
  output tmode_e           mode,
  output logic             ie,
  output logic             ip,
  output logic [PER_W-1:0] period
);
  localparam int IP_BIT = PER_W;
  localparam int IE_BIT = PER_W + 1;

  assign period = word[PER_W-1:0];
  assign ip     = word[IP_BIT];
  assign ie     = word[IE_BIT];
  assign mode   = tmode_e'(word[CNT_W-1:CNT_W-2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
    end else if (wr) begin
      word <= wdata;
    end else if (hit && ie && !ip) begin
      word[IP_BIT] <= 1'b1;
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq
);
  localparam int PER_W = CNT_W - 4;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] word_q;
  logic [PER_W-1:0] period;
  tmode_e           mode;
  logic             ie, ip, hit;

  tick_match #(.PER_W(PER_W)) u_match (
    .cnt_lo (cnt_q[PER_W-1:0]),
    .period (period),
    .hit    (hit)
  );

  tick_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_en && wr_sel),
    .load_val (wr_data),
    .mode     (mode),
    .hit      (hit),
    .cnt      (cnt_q)
  );

  tick_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (wr_en && !wr_sel),
    .wdata  (wr_data),
    .hit    (hit),
    .word   (word_q),
    .mode   (mode),
    .ie     (ie),
    .ip     (ip),
    .period (period)
  );

  assign rd_data = rd_sel ? cnt_q : word_q;
  assign irq     = ip && ie;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] word,
  input logic             irq
);
  localparam int PW = CNT_W - 4;
  logic       m_hit, cwr, wwr, m_ie, m_ip;
  logic [1:0] m_md;
  assign m_hit = (cnt[PW-1:0] == word[PW-1:0]);
  assign cwr   = wr_en && wr_sel;
  assign wwr   = wr_en && !wr_sel;
  assign m_ip  = word[PW];
  assign m_ie  = word[PW+1];
  assign m_md  = word[CNT_W-1:CNT_W-2];

  a_r2_count_load: assert property (@(posedge clk) disable iff (!rst_n)
    cwr |=> cnt == $past(wr_data));
  a_r5_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_md == 2'd0 && !cwr) |=> $stable(cnt));
  a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (m_md == 2'd1 && m_hit && !cwr) |=> cnt == '0);
  a_r7_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_md == 2'd2 && m_hit && !cwr) |=> $stable(cnt));
  a_r8_free_step: assert property (@(posedge clk) disable iff (!rst_n)
    (m_md == 2'd3 && !cwr) |=> cnt == $past(cnt) + CNT_W'(1));
  a_r9_pending_set: assert property (@(posedge clk) disable iff (!rst_n)
    (m_hit && m_ie && !m_ip && !wwr) |=> word[PW]);
  a_r9_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (m_ip && !wwr) |=> word[PW]);
  a_r10_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (wwr && !wr_data[PW]) |=> !irq);
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_sel  (wr_sel),
  .wr_data (wr_data),
  .cnt     (cnt_q),
  .word    (word_q),
  .irq     (irq)
);

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
  localparam int W  = 32;
  localparam int PW = W - 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n = 1'b0, wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         irq;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  tick_timer #(.CNT_W(W)) u_tick_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq));

  // behavioural reference
  logic [W-1:0] m_cnt, m_word;
  always @(posedge clk) begin : model
    logic [W-1:0] nc, nw;
    bit h;
    int md;
    if (!rst_n) begin
      m_cnt = '0; m_word = '0;
    end else begin
      h  = (m_cnt % (1 << PW)) == (m_word % (1 << PW));
      md = int'(m_word >> (W - 2));
      nc = m_cnt; nw = m_word;
      if (wr_en && wr_sel) nc = wr_data;
      else if (md == 1) nc = h ? 0 : m_cnt + 1;
      else if (md == 2) nc = h ? m_cnt : m_cnt + 1;
      else if (md == 3) nc = m_cnt + 1;
      if (wr_en && !wr_sel) nw = wr_data;
      else if (h && m_word[PW+1] && !m_word[PW]) nw[PW] = 1'b1;
      m_cnt = nc; m_word = nw;
    end
  end

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R2 per-cycle read", rd_data, rd_sel ? m_cnt : m_word);
    chk("R10 per-cycle irq", W'(irq), W'(m_word[PW+1] & m_word[PW]));
  end

  function automatic logic [W-1:0] mk(int md, bit ie, bit ip, int per);
    return {md[1:0], ie, ip, per[PW-1:0]};
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wr(bit sel, logic [W-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic look(bit sel, logic [W-1:0] exp, string tag);
    rd_sel = sel; #2;
    chk(tag, rd_data, exp);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    look(0, '0, "R1 control word after reset");
    look(1, '0, "R1 counter after reset");
    chk("R1 irq after reset", W'(irq), '0);

    // restart mode, period 3
    wr(1, '0);
    wr(0, mk(1, 1, 0, 3));
    look(1, 0, "R6 start");
    look(0, mk(1, 1, 0, 3), "R3 word readback");
    idle(3);
    look(1, 3, "R6 reaches period");
    idle(1);
    look(1, 0, "R6 back to zero");
    look(0, mk(1, 1, 1, 3), "R9 pending set on hit");
    chk("R10 irq raised", W'(irq), 1);
    idle(4);
    look(1, 0, "R6 periodic");
    look(0, mk(1, 1, 1, 3), "R9 pending sticky");
    wr(0, mk(1, 1, 0, 3));
    chk("R10 clear cancels irq", W'(irq), 0);
    look(1, 1, "R6 counting after clear");

    // single-run, enable off, period 4
    wr(0, mk(2, 0, 0, 4));
    wr(1, 0);
    idle(4);
    look(1, 4, "R7 reaches period");
    idle(3);
    look(1, 4, "R7 stopped");
    look(0, mk(2, 0, 0, 4), "R9 no pending with enable off");
    wr(0, mk(2, 0, 0, 6));
    idle(1);
    look(1, 5, "R7 resumes after period rewrite");

    // free-run across the low-bit wrap, period 2
    wr(0, mk(3, 1, 0, 2));
    wr(1, 32'h0FFF_FFFE);
    idle(2);
    look(1, 32'h1000_0000, "R4 upper bits carry");
    idle(2);
    look(0, mk(3, 1, 0, 2), "R4 no hit before wrap");
    idle(1);
    look(1, 32'h1000_0003, "R8 runs through hit");
    look(0, mk(3, 1, 1, 2), "R4 hit after wrap");
    wr(1, 100);
    look(1, 100, "R2 load overrides increment");
    idle(1);
    look(1, 101, "R2 counting from loaded value");

    // frozen mode, period 7
    wr(0, mk(0, 1, 0, 7));
    wr(1, 7);
    idle(1);
    look(1, 7, "R5 counter holds");
    look(0, mk(0, 1, 1, 7), "R5 hit sets pending while frozen");
    idle(2);
    look(1, 7, "R5 still holding");
    wr(0, mk(0, 1, 0, 7));
    look(0, mk(0, 1, 0, 7), "R9 cleared by write");
    wr(0, mk(0, 1, 0, 7));
    look(0, mk(0, 1, 0, 7), "R11 write beats hardware set");
    idle(1);
    look(0, mk(0, 1, 1, 7), "R9 re-set on lasting hit");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule